// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Divider

This block produces a clock-enable stream whose rising edges arrive at m/n of the input clock rate, with a programmable high time. An accumulator adds m on every input cycle and wraps modulo n. The output is high whenever twice the accumulator value is below a high-time count. This gives a duty cycle of h/(2n).

The divider settings come from a configuration bank in encoded form. The n setting is stored as the complement of (n − m). The high-time setting is stored as a complement. Both are decoded inside the block. Only the dual-edge mode code runs the divider, and only for a meaningful ratio. Every other case is bypass, in which the enable stays high on every cycle and the input rate passes through unchanged.

Top module: `mnd_frac_divider`

## Requirements
- R1: While rst_n is low, clk_en is 0 and the accumulator is cleared.
- R2: The divisor is decoded as n = (~n_code & mask) + m_val, computed one bit wider than W so that it never overflows (mask = 2^W − 1).
- R3: The high-time count is h = ~d_code & mask. In divider mode, clk_en goes high when 2·acc < h. Programming d_code = ~n gives a 50% duty cycle.
- R4: In divider mode the accumulator adds m_val on each cycle and subtracts n when the sum reaches n or more. Each clk_en value is registered from the accumulator value held before that clock edge.
- R5: The divider runs only when mode equals 2. Modes 0, 1 and 3 are bypass, in which clk_en is 1 one cycle later and the accumulator is held at 0.
- R6: Mode 2 with m equal to the decoded n is treated as bypass: clk_en stays at 1.
- R7: Mode 2 with m = 0, a decoded n of 0, or m > n is treated as bypass.
- R8: If the accumulator is not below the current decoded n, for example after a configuration change, it is cleared to 0 on the next edge.
- R9: For m ≤ n/2 with a 50% duty cycle, every window of n consecutive cycles holds exactly m rising edges of clk_en.
- R10: With W = 9, the ratios 3/8, 2/9, 4/9, 1/1, 11/50 and 107/269 all follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mode code: 2 selects the divider, any other value selects bypass |
| m_val | input | W | Numerator m |
| n_code | input | W | Encoded divisor, ~(n − m) |
| d_code | input | W | Encoded high-time count, ~h |
| clk_en | output | 1 | Divided clock enable |

## Verification
Every clk_en value is due one clock after the accumulator state and the configuration that produce it. A bypass or mode change therefore shows at the output after exactly one edge, and so does the resync of R8.

The bench keeps a behavioural model that steps on the same rising edge as the design. It compares the model with the output on every falling edge, so each comparison lands half a cycle after the edge that made the value.

The rate requirement is checked separately. After the accumulator has been cleared by a bypass cycle, the bench counts rising edges over a window of exactly n cycles.

// File: rtl/mnd_frac_divider.sv
module mnd_frac_divider #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] m_val,
  input  logic [W-1:0] n_code,
  input  logic [W-1:0] d_code,
  output logic         clk_en
);
  localparam int NW = W + 1;
  localparam logic [1:0] MODE_DIV = 2'd2;

  logic [NW-1:0] n_dec;
  logic [W-1:0]  high_cnt;
  logic          active;
  logic [NW-1:0] acc_q, acc_d;
  logic [NW:0]   sum;
  logic          hit;

  // R2: decoded divisor, one bit wider than W
  assign n_dec    = {1'b0, ~n_code} + {1'b0, m_val};
  // R3: decoded high-time count
  assign high_cnt = ~d_code;
  // R5, R6, R7: divider runs only in mode 2 with 0 < m < n
  assign active   = (mode == MODE_DIV) && (n_dec != '0) && (m_val != '0)
                    && ({1'b0, m_val} < n_dec);
  assign sum      = {1'b0, acc_q} + {2'b0, m_val};
  assign hit      = {acc_q, 1'b0} < {2'b0, high_cnt};

  always_comb begin
    if (!active)                   acc_d = '0;
    else if (acc_q >= n_dec)       acc_d = '0;
    else if (sum >= {1'b0, n_dec}) acc_d = NW'(sum - {1'b0, n_dec});
    else                           acc_d = sum[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      clk_en <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      clk_en <= active ? hit : 1'b1;
    end
  end

  // R5
  bypass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_DIV) |=> clk_en);
  // R6
  equal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DIV && {1'b0, m_val} == n_dec) |=> clk_en);
  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (acc_q < $past(n_dec)));
  // R3
  zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && d_code == {W{1'b1}}) |=> !clk_en);
  // R8
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && acc_q >= n_dec) |=> (acc_q == '0));
endmodule

// File: tb/mnd_frac_divider_test.sv
module mnd_frac_divider_test;
  localparam int W = 9;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [W-1:0] m_val = '0, n_code = '0, d_code = '0;
  logic clk_en;

  int tests = 0;
  int fails = 0;
  int macc = 0;
  int mexp = 0;

  always #4 clk = ~clk;

  mnd_frac_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .m_val(m_val),
    .n_code(n_code), .d_code(d_code), .clk_en(clk_en)
  );

  always @(posedge clk) begin
    int nd, h, mm;
    bit act;
    if (!rst_n) begin
      macc = 0;
      mexp = 0;
    end else begin
      mm  = int'(m_val);
      nd  = ((~int'(n_code)) & MASK) + mm;
      h   = (~int'(d_code)) & MASK;
      act = (mode == 2'd2) && nd != 0 && mm != 0 && mm < nd;
      if (!act) begin
        mexp = 1;
        macc = 0;
      end else begin
        mexp = (2 * macc < h) ? 1 : 0;
        if (macc >= nd) macc = 0;
        else begin
          macc = macc + mm;
          if (macc >= nd) macc = macc - nd;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: clk_en=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg(input int md, input int m, input int n, input int h);
    mode   = 2'(md);
    m_val  = W'(m);
    n_code = W'(~(n - m) & MASK);
    d_code = W'(~h & MASK);
  endtask

  task automatic run(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(tag, int'(clk_en), mexp);
    end
  endtask

  task automatic rate(input int m, input int n, input string tag);
    int rises;
    int prev;
    cfg(0, 0, 0, 0);
    run(1, "R5");
    cfg(2, m, n, n);
    run(2, tag);
    prev = int'(clk_en);
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, int'(clk_en), mexp);
      if (prev == 0 && clk_en == 1'b1) rises++;
      prev = int'(clk_en);
    end
    tests++;
    if (rises != m) begin
      fails++;
      $display("FAIL %s R9: rising edges=%0d expected %0d for %0d/%0d", tag, rises, m, m, n);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cfg(2, 3, 8, 8);
    repeat (3) @(negedge clk);
    check("R1", int'(clk_en), 0);
    rst_n = 1'b1;
    run(20, "R4");
    cfg(2, 3, 8, 4);
    run(20, "R3");
    cfg(2, 3, 8, 0);
    run(10, "R3");
    cfg(0, 3, 8, 8);
    run(4, "R5");
    cfg(1, 3, 8, 8);
    run(4, "R5");
    cfg(3, 3, 8, 8);
    run(4, "R5");
    cfg(2, 5, 5, 5);
    run(6, "R6");
    cfg(2, 0, 9, 9);
    run(6, "R7");
    cfg(2, 0, 0, 0);
    run(6, "R7");
    rate(3, 8, "R10");
    rate(2, 9, "R10");
    rate(11, 50, "R10");
    rate(1, 4, "R9");
    cfg(2, 4, 9, 9);
    run(30, "R10");
    cfg(2, 1, 1, 1);
    run(5, "R10");
    cfg(2, 107, 269, 269);
    run(300, "R10");
    cfg(2, 1, 4, 4);
    run(12, "R8");
    cfg(2, 2, 9, 5);
    n_code = W'(~7 & MASK);
    run(30, "R2");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(clk_en), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule